// File: doc/BRIEF.md
# Bit-Serial Bus Cycle Decoder

This block sits behind a memory that is reached over a single line of a parallel data bus. The host drives ordinary bus cycles with chip-enable, write-enable and output-enable. The block samples those strobes with the system clock and sorts every finished cycle into one of three kinds: a write carrying 0, a write carrying 1, or a read. Commands are not opcodes. They are particular orderings of these cycle kinds.

From the cycle stream the decoder recognises four things: the arming sequence, a 16-bit address shifted in most significant bit first, a byte-serial sequential read with automatic address increment, and a data-load phase followed by the command that commits the load. It drives the memory address and returns one data bit per read cycle. Its single-cycle event pulses go to a downstream write sequencer and protection logic. Any ordering outside the protocol drops the block to idle and clears the write-enable latch.

Top module: `bus_cycle_decoder`

## Requirements
- R1: A write cycle is chip-enable low, write-enable low, output-enable high. A read cycle is chip-enable low, output-enable low, write-enable high. A write's bit is the data-line level seen last before the cycle ends. `ioOe` is high only while a read cycle is active.
- R2: A read, then a write of 0, then a read pulses `seqReset`, sets `wrEnLatch` and arms the decoder. This works from any state.
- R3: Once armed, and until 16 address bits have been loaded, every read returns 1 on `ioOut`.
- R4: The next 16 write cycles after arming are shifted into `memAddr`, most significant bit first.
- R5: After the address, each read returns the next bit of `memData` (bit 7 first). After bit 0, `memAddr` increments. Address 2^ARR_BITS-1 rolls over to 0.
- R6: A write of 1 that follows the last bit of a byte ends the read. The block goes idle and `wrEnLatch` is kept.
- R7: The following are illegal: a read, write, write ordering (unless the read was the arming read or a read made while armed); a read during address loading; a write of 1 in the middle of a byte. Each one pulses `illegalEvt`, sends the block idle and clears `wrEnLatch`. While idle, reads return 1.
- R8: Write cycles after a complete address each pulse `dataBitValid`, with the bit on `dataBitVal`.
- R9: After data loading, a read, write of 1, read pulses `nvStart` and goes idle. This needs a whole number of bytes (at least one) and `wrEnLatch` set. Otherwise the ordering is illegal as in R7.
- R10: While `nvBusy` is high, the arming sequence is ignored: no `seqReset`, and `wrEnLatch` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Bus chip-enable, active low |
| weN | input | 1 | Bus write-enable, active low |
| oeN | input | 1 | Bus output-enable, active low |
| ioIn | input | 1 | Data line level seen at the pin |
| ioOut | output | 1 | Bit driven onto the data line |
| ioOe | output | 1 | Data line driver enable |
| memData | input | 8 | Array byte at `memAddr` |
| memAddr | output | 16 | Current array address |
| nvBusy | input | 1 | Nonvolatile write in progress |
| wrEnLatch | output | 1 | Internal write-enable latch |
| seqReset | output | 1 | Pulse: arming sequence accepted |
| illegalEvt | output | 1 | Pulse: illegal ordering seen |
| nvStart | output | 1 | Pulse: commit command accepted |
| dataBitValid | output | 1 | Pulse: one data bit loaded |
| dataBitVal | output | 1 | Value of the loaded data bit |
| busIdle | output | 1 | Decoder is in the idle state |

## Verification
The main stream covers the full read path: arming from idle, an extra armed read, an address at the array's top, and sixteen reads across the rollover. This separates armed ones from memory bits and shows the wrap to zero. Directed orderings follow. A mid-byte write of 1 and a byte-boundary write of 1 must differ in the latch they leave behind. A read, write, write after data and a read inside the address phase must both count as illegal. A whole-byte commit and a partial-byte commit must differ in whether `nvStart` appears. An arming attempt while busy must change nothing.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {K_NONE, K_RD, K_W0, K_W1} cyc_kind_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_ADDR, S_LOADED, S_READ, S_DATA, S_PEND
  } dec_state_t;

  typedef struct packed {
    logic wrEnd;
    logic rdEnd;
    logic bitVal;
  } cyc_evt_t;

  typedef struct packed {
    logic             addrShift;
    logic             addrInc;
    logic             fromMem;
    logic [IDX_W-1:0] bitIdx;
  } path_strb_t;
endpackage

// File: rtl/bcd_pins.sv
module bcd_pins import bcd_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     ceN,
  input  logic     weN,
  input  logic     oeN,
  input  logic     ioIn,
  output cyc_evt_t evt,
  output logic     rdAct
);
  localparam int PIN_N = 4;

  logic [PIN_N-1:0] rawPins;
  logic [PIN_N-1:0] syncd;
  assign rawPins = {ioIn, oeN, weN, ceN};

  for (genvar g = 0; g < PIN_N; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg <= '1;
      else       stg <= {stg[SYNC_STAGES-2:0], rawPins[g]};
    end
    assign syncd[g] = stg[SYNC_STAGES-1];
  end

  logic ceS, weS, oeS, ioS;
  assign {ioS, oeS, weS, ceS} = syncd;

  logic wrAct, wrPrev, rdPrev, bitHold;
  assign wrAct = !ceS && !weS && oeS;
  assign rdAct = !ceS && !oeS && weS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      rdPrev  <= 1'b0;
      bitHold <= 1'b1;
    end else begin
      wrPrev <= wrAct;
      rdPrev <= rdAct;
      if (wrAct) bitHold <= ioS;
    end
  end

  assign evt.wrEnd  = wrPrev && !wrAct;
  assign evt.rdEnd  = rdPrev && !rdAct;
  assign evt.bitVal = bitHold;

  assert_one_end_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evt.wrEnd, evt.rdEnd}));
endmodule

// File: rtl/bcd_ctrl.sv
module bcd_ctrl import bcd_pkg::*; #(
  parameter int ADDR_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  cyc_evt_t   evt,
  input  logic       nvBusy,
  output path_strb_t strb,
  output logic       wrEnLatch,
  output logic       seqReset,
  output logic       illegalEvt,
  output logic       nvStart,
  output logic       dataBitValid,
  output logic       dataBitVal,
  output logic       busIdle
);
  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(ADDR_W - 1);

  dec_state_t state, stN;
  cyc_kind_t  h1, h2, cur;
  logic m1, m2;
  logic [CNT_W-1:0] addrCnt, addrCntN;
  logic [IDX_W-1:0] rdIdx, rdIdxN, dCnt, dCntN;
  logic dAny, dAnyN, latchN, illN, nvN, rstP, dvN, shiftC, incC;
  logic anyEnd, isRd, isWr, isReset, isRww;

  assign isRd   = evt.rdEnd;
  assign isWr   = evt.wrEnd;
  assign anyEnd = isRd || isWr;
  assign cur    = isRd ? K_RD : (evt.bitVal ? K_W1 : K_W0);

  assign isReset = isRd && h1 == K_W0 && h2 == K_RD && !nvBusy;
  assign isRww   = isWr && (h1 == K_W0 || h1 == K_W1) && h2 == K_RD && !m2;

  always_comb begin
    stN = state; latchN = wrEnLatch; addrCntN = addrCnt;
    rdIdxN = rdIdx; dCntN = dCnt; dAnyN = dAny;
    illN = 1'b0; nvN = 1'b0; rstP = 1'b0; dvN = 1'b0;
    shiftC = 1'b0; incC = 1'b0;
    if (isReset) begin
      stN = S_ARMED; latchN = 1'b1; rstP = 1'b1;
      addrCntN = '0; rdIdxN = '0; dCntN = '0; dAnyN = 1'b0;
    end else if (isRww) begin
      stN = S_IDLE; latchN = 1'b0; illN = 1'b1;
    end else if (anyEnd) begin
      unique case (state)
        S_ARMED: if (isWr) begin
          shiftC = 1'b1; addrCntN = CNT_W'(1); stN = S_ADDR;
        end
        S_ADDR: begin
          if (isWr) begin
            shiftC = 1'b1;
            if (addrCnt == LAST_BIT) stN = S_LOADED;
            else addrCntN = addrCnt + 1'b1;
          end else begin
            stN = S_IDLE; latchN = 1'b0; illN = 1'b1;
          end
        end
        S_LOADED: begin
          if (isRd) begin
            rdIdxN = IDX_W'(1); stN = S_READ;
          end else begin
            dvN = 1'b1; dCntN = IDX_W'(1); dAnyN = 1'b1; stN = S_DATA;
          end
        end
        S_READ: begin
          if (isRd) begin
            rdIdxN = rdIdx + 1'b1;
            if (rdIdx == '1) incC = 1'b1;
          end else if (evt.bitVal) begin
            stN = S_IDLE;
            if (rdIdx != '0) begin
              latchN = 1'b0; illN = 1'b1;
            end
          end
        end
        S_DATA: begin
          if (isWr) begin
            dvN = 1'b1; dCntN = dCnt + 1'b1; dAnyN = 1'b1;
          end else stN = S_PEND;
        end
        S_PEND: if (isRd) begin
          stN = S_IDLE;
          if (h1 == K_W1 && h2 == K_RD && wrEnLatch && dCnt == '0 && dAny) nvN = 1'b1;
          else begin
            latchN = 1'b0; illN = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; h1 <= K_NONE; h2 <= K_NONE; m1 <= 1'b0; m2 <= 1'b0;
      addrCnt <= '0; rdIdx <= '0; dCnt <= '0; dAny <= 1'b0; wrEnLatch <= 1'b0;
      seqReset <= 1'b0; illegalEvt <= 1'b0; nvStart <= 1'b0;
      dataBitValid <= 1'b0; dataBitVal <= 1'b0;
    end else begin
      state <= stN; addrCnt <= addrCntN; rdIdx <= rdIdxN;
      dCnt <= dCntN; dAny <= dAnyN; wrEnLatch <= latchN;
      seqReset <= rstP; illegalEvt <= illN; nvStart <= nvN;
      dataBitValid <= dvN;
      if (dvN) dataBitVal <= evt.bitVal;
      if (anyEnd) begin
        h2 <= h1; h1 <= cur;
        m2 <= m1; m1 <= isReset || (isRd && state == S_ARMED);
      end
    end
  end

  assign strb.addrShift = shiftC;
  assign strb.addrInc   = incC;
  assign strb.fromMem   = (state == S_LOADED) || (state == S_READ);
  assign strb.bitIdx    = rdIdx;
  assign busIdle        = (state == S_IDLE);

  assert_latch_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    seqReset |-> wrEnLatch);
  assert_illegal_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    illegalEvt |-> (busIdle && !wrEnLatch));
  assert_commit_from_pend_R9: assert property (@(posedge clk) disable iff (!rstN)
    nvStart |-> (busIdle && $past(state == S_PEND)));
  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evt.rdEnd && nvBusy) |=> !seqReset);
endmodule

// File: rtl/bcd_path.sv
module bcd_path import bcd_pkg::*; #(
  parameter int ADDR_W   = 16,
  parameter int ARR_BITS = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  path_strb_t        strb,
  input  logic              bitVal,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              ioOut
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'((64'd1 << ARR_BITS) - 64'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) memAddr <= '0;
    else if (strb.addrShift) memAddr <= {memAddr[ADDR_W-2:0], bitVal};
    else if (strb.addrInc) memAddr <= (memAddr == TOP_ADDR) ? '0 : memAddr + 1'b1;
  end

  logic [IDX_W-1:0] selIdx;
  assign selIdx = IDX_W'(BYTE_W - 1) - strb.bitIdx;
  assign ioOut  = strb.fromMem ? memData[selIdx] : 1'b1;

  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.addrInc && !strb.addrShift && memAddr == TOP_ADDR) |=> (memAddr == '0));
endmodule

// File: rtl/bus_cycle_decoder.sv
module bus_cycle_decoder import bcd_pkg::*; #(
  parameter int ADDR_W      = 16,
  parameter int ARR_BITS    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              ioIn,
  output logic              ioOut,
  output logic              ioOe,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              nvBusy,
  output logic              wrEnLatch,
  output logic              seqReset,
  output logic              illegalEvt,
  output logic              nvStart,
  output logic              dataBitValid,
  output logic              dataBitVal,
  output logic              busIdle
);
  cyc_evt_t   evt;
  path_strb_t strb;

  bcd_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .ioIn(ioIn),
    .evt(evt), .rdAct(ioOe));

  bcd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .evt(evt), .nvBusy(nvBusy), .strb(strb),
    .wrEnLatch(wrEnLatch), .seqReset(seqReset), .illegalEvt(illegalEvt),
    .nvStart(nvStart), .dataBitValid(dataBitValid), .dataBitVal(dataBitVal),
    .busIdle(busIdle));

  bcd_path #(.ADDR_W(ADDR_W), .ARR_BITS(ARR_BITS)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .bitVal(evt.bitVal),
    .memData(memData), .memAddr(memAddr), .ioOut(ioOut));
endmodule

// File: tb/bus_cycle_decoder_tb.sv
module bus_cycle_decoder_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, ioIn = 1'b1, nvBusy = 1'b0;
  logic ioOut, ioOe, wrEnLatch, seqReset, illegalEvt, nvStart;
  logic dataBitValid, dataBitVal, busIdle;
  logic [7:0]  memData;
  logic [15:0] memAddr;

  always #5 clk = ~clk;

  bus_cycle_decoder u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .ioIn(ioIn),
    .ioOut(ioOut), .ioOe(ioOe), .memData(memData), .memAddr(memAddr),
    .nvBusy(nvBusy), .wrEnLatch(wrEnLatch), .seqReset(seqReset),
    .illegalEvt(illegalEvt), .nvStart(nvStart), .dataBitValid(dataBitValid),
    .dataBitVal(dataBitVal), .busIdle(busIdle));

  function automatic logic [7:0] memAt(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign memData = memAt(memAddr);

  int checks = 0, errors = 0;
  int nRst = 0, nIll = 0, nNv = 0, nData = 0;
  logic [15:0] dataShift = '0;
  logic wrOe = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) if (rstN) begin
    if (seqReset) nRst <= nRst + 1;
    if (illegalEvt) nIll <= nIll + 1;
    if (nvStart) nNv <= nNv + 1;
    if (dataBitValid) begin
      nData <= nData + 1;
      dataShift <= {dataShift[14:0], dataBitVal};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic b);
    @(negedge clk); ceN = 1'b0; weN = 1'b0; oeN = 1'b1; ioIn = b;
    repeat (5) @(negedge clk);
    wrOe = ioOe;
    weN = 1'b1; ceN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic busRead(output logic b, output logic oe);
    @(negedge clk); ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    repeat (5) @(negedge clk);
    b = ioOut; oe = ioOe;
    oeN = 1'b1; ceN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic arm();
    logic b, oe;
    busRead(b, oe); busWrite(1'b0); busRead(b, oe);
  endtask

  task automatic sendAddr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) busWrite(a[i]);
  endtask

  // 0 = write 0, 1 = write 1, 2 = read expecting 1, 3 = read expecting array bit
  localparam int NV = 37;
  localparam logic [1:0] VEC [NV] = '{
    2'd2, 2'd0, 2'd2, 2'd2,
    2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1,
    2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1,
    2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3,
    2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3,
    2'd1};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic b, oe;
    logic [15:0] mAddr;
    int rdPos;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1 ioOe at reset", ioOe, 0);
    chk("R2 latch at reset", wrEnLatch, 0);
    chk("R7 idle at reset", busIdle, 1);
    chk("R4 address at reset", memAddr, 0);

    // table: arm, armed read, address 3FFF, sixteen reads over the rollover
    mAddr = '0; rdPos = 0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][1] == 1'b0) begin
        busWrite(VEC[i][0]);
        if (i >= 4 && i < 20) mAddr = {mAddr[14:0], VEC[i][0]};
        if (i == 19) chk("R4 loaded address", memAddr, 16'h3FFF);
      end else begin
        busRead(b, oe);
        chk("R1 ioOe in read", oe, 1);
        if (VEC[i][0] == 1'b0) chk("R3 ones before address", b, 1);
        else begin
          chk("R5 serial data", b, memAt(mAddr)[7 - rdPos]);
          rdPos++;
          if (rdPos == 8) begin
            rdPos = 0;
            mAddr = (mAddr == 16'h3FFF) ? 16'h0000 : mAddr + 16'd1;
          end
        end
      end
      if (i == 2) begin
        chk("R2 reset pulse", nRst, 1);
        chk("R2 latch set", wrEnLatch, 1);
      end
    end
    chk("R5 rollover address", memAddr, 16'h0001);
    chk("R6 idle after end", busIdle, 1);
    chk("R6 latch kept", wrEnLatch, 1);
    chk("R6 no illegal", nIll, 0);

    // mid-byte write of 1
    arm(); sendAddr(16'h0010);
    for (int k = 0; k < 3; k++) busRead(b, oe);
    busWrite(1'b1);
    chk("R7 midbyte illegal", nIll, 1);
    chk("R7 midbyte idle", busIdle, 1);
    chk("R7 midbyte latch", wrEnLatch, 0);
    busRead(b, oe);
    chk("R7 idle read ones", b, 1);

    // read, write, write after a full byte
    arm(); sendAddr(16'h0020);
    for (int k = 0; k < 8; k++) begin
      busRead(b, oe);
      chk("R5 byte at 0020", b, memAt(16'h0020)[7 - k]);
    end
    chk("R5 increment", memAddr, 16'h0021);
    busWrite(1'b0); busWrite(1'b0);
    chk("R7 rww illegal", nIll, 2);
    chk("R7 rww latch", wrEnLatch, 0);

    // read during address load
    arm();
    for (int k = 0; k < 5; k++) busWrite(1'b1);
    busRead(b, oe);
    chk("R7 read in address illegal", nIll, 3);
    chk("R7 read in address idle", busIdle, 1);

    // data load then commit
    arm(); sendAddr(16'h0100);
    for (int k = 15; k >= 0; k--) busWrite(k[0] ^ k[1] ? 1'b0 : 1'b1);
    chk("R1 ioOe low in write", wrOe, 0);
    chk("R8 data bit count", nData, 16);
    chk("R8 data bits", dataShift, 16'b1001100110011001);
    busRead(b, oe); busWrite(1'b1); busRead(b, oe);
    chk("R9 commit pulse", nNv, 1);
    chk("R9 idle after commit", busIdle, 1);
    chk("R9 no illegal", nIll, 3);

    // partial byte commit
    arm(); sendAddr(16'h0200);
    for (int k = 0; k < 5; k++) busWrite(1'b1);
    busRead(b, oe); busWrite(1'b1); busRead(b, oe);
    chk("R9 partial no commit", nNv, 1);
    chk("R9 partial latch", wrEnLatch, 0);

    // arming while busy
    nvBusy = 1'b1;
    arm();
    chk("R10 no reset pulse", nRst, 6);
    chk("R10 latch unchanged", wrEnLatch, 0);
    nvBusy = 1'b0;
    arm();
    chk("R2 arm after busy", wrEnLatch, 1);
    chk("R2 reset count", nRst, 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule